// File: doc/BRIEF.md
# Multiplexed Converter Serial Slave Controller

This block is the digital sequencer that sits in front of a multiplexed converter and serves a four-wire serial port as a slave. It loops through three phases: a conversion, a low-power hold in which the finished result waits, and a readout in which the host clocks the result out while it shifts in the channel choice for the conversion that follows. A conversion is modelled as a fixed number of system clock cycles. The result word is taken from an input port at the moment the conversion ends.

The host lowers the select line to watch the status bit on the data output. That bit reads 1 while a conversion runs and 0 once a result is waiting. The host then clocks out a 32-bit word: the status bit, a zero bit, the sign, 23 result bits, the five-bit channel selection that produced the result, and an even-parity bit. The first eight bits the host sends during a readout form a command. When it carries the load code, it replaces the channel selection used for the next conversion. The select, clock and data pins are synchronised into the system clock domain. The output enable models the tri-state driver.

Top module: `mxs_serial_slave`

## Requirements
- R1: After reset a conversion is in progress and the channel selection in use is 00000 (differential pair, positive input on channel 0, negative on channel 1), shown on `mux_sel_o`.
- R2: `sdo_oe_o` is 0 while `cs_n` is high and 1 while `cs_n` is low.
- R3: With `cs_n` low, `sdo_o` reads 1 while a conversion runs and 0 once a result is waiting and no rising SCK edge has yet occurred.
- R4: A conversion lasts CONV_CYCLES clocks. The block then holds the result, and stays holding it for as long as `cs_n` is high.
- R5: If `cs_n` rises before the first rising SCK edge of a readout, the block returns to holding: no conversion starts, and a later readout returns the same word.
- R6: The readout word is sent MSB first, and each falling SCK edge advances it by one bit. Its layout is: bit 31 = 0 (result ready), bit 30 = 0, bit 29 = `conv_data_i[23]` (sign), bits 28..6 = `conv_data_i[22:0]`, bits 5..1 = the selection, bit 0 = even parity, which makes the count of ones in bits 31..0 even.
- R7: The 32nd rising SCK edge of a readout starts a new conversion at once.
- R8: A rising `cs_n` after at least one rising SCK edge aborts the readout and starts a new conversion at once.
- R9: SDI is sampled on rising SCK edges from the first one. The first eight bits, MSB first, form a command. When bits 7..5 equal 101, bits 4..0 (bit 4 = single-ended flag, bits 3..0 = channel) become the selection for the next conversion. Any other code, or a readout that ends before eight bits, leaves the selection unchanged.
- R10: A new selection takes effect when the next conversion starts. `mux_sel_o` shows the selection of the conversion in progress or last performed, and bits 5..1 of each word carry the selection of the conversion being read out.
- R11: The result is captured when the conversion ends. Later changes of `conv_data_i` do not alter the word being held or read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select from the host |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial command data from the host |
| conv_data_i | input | 24 | Sign (bit 23) and 23-bit result of the running conversion |
| sdo_o | output | 1 | Serial data / status output |
| sdo_oe_o | output | 1 | Output driver enable (0 = high impedance) |
| mux_sel_o | output | 5 | Channel selection of the current conversion |

## Verification
The bench builds the block with CONV_CYCLES = 40 and SYNC_STAGES = 2. The short conversion lets many complete convert–hold–readout cycles fit in one run. These cover the load, keep and invalid command codes and several result patterns, including both sign values. Within the same run the bench also reaches a select pulse with no clock, an abort after four bits (too few for a command) and an abort right after the eighth bit.

// File: rtl/mxs_pkg.sv
package mxs_pkg;
  // Protocol geometry (fixed by the serial word format)
  localparam int FRAME_W  = 32;
  localparam int RES_W    = 23;
  localparam int ADDR_W   = 5;
  localparam int CMD_W    = 8;
  localparam int CODE_W   = CMD_W - ADDR_W;
  localparam logic [CODE_W-1:0] CODE_LOAD = 3'b101;

  typedef enum logic [1:0] {
    ST_CONVERT = 2'd0,
    ST_SLEEP   = 2'd1,
    ST_XFER    = 2'd2
  } mxs_state_e;

  typedef struct packed {
    logic              load;
    logic [ADDR_W-1:0] sel;
  } mxs_cmd_t;

  // Assemble the readout word; parity makes the total count of ones even.
  function automatic logic [FRAME_W-1:0] build_frame(input logic sign,
                                                     input logic [RES_W-1:0] res,
                                                     input logic [ADDR_W-1:0] sel);
    logic [FRAME_W-1:1] body;
    body = {1'b0, 1'b0, sign, res, sel};
    return {body, ^body};
  endfunction

  // Split an 8-bit command into load flag and selection.
  function automatic mxs_cmd_t decode_cmd(input logic [CMD_W-1:0] word);
    mxs_cmd_t c;
    c.load = (word[CMD_W-1 -: CODE_W] == CODE_LOAD);
    c.sel  = word[ADDR_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/mxs_pin_sync.sv
module mxs_pin_sync #(
  parameter int                WIDTH   = 3,
  parameter int                STAGES  = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] level_o
);
  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] pipe_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL[b]}};
        else        pipe_q <= {pipe_q[STAGES-2:0], pin_i[b]};
      end
      assign level_o[b] = pipe_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/mxs_conv_timer.sv
module mxs_conv_timer #(
  parameter int CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  // Reset itself launches the first conversion.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == LAST) && !start_i;

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);
  assert_idle_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> cnt_q == '0);
endmodule

// File: rtl/mxs_frame_shifter.sv
module mxs_frame_shifter
  import mxs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               shift_i,
  input  logic               sample_i,
  input  logic               sdi_i,
  output logic               msb_o,
  output logic               last_o,
  output logic               cmd_done_o,
  output logic [CMD_W-1:0]   cmd_word_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] frame_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CMD_W-2:0]   cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      cnt_q   <= '0;
      cmd_q   <= '0;
    end else begin
      if (load_i) begin
        frame_q <= frame_i;
        cnt_q   <= '0;
        cmd_q   <= '0;
      end else begin
        if (shift_i) frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
        if (sample_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q < CNT_W'(CMD_W - 1)) cmd_q <= {cmd_q[CMD_W-3:0], sdi_i};
        end
      end
    end
  end

  assign msb_o      = frame_q[FRAME_W-1];
  assign last_o     = (cnt_q == CNT_W'(FRAME_W - 1));
  assign cmd_done_o = sample_i && (cnt_q == CNT_W'(CMD_W - 1));
  assign cmd_word_o = {cmd_q, sdi_i};

  assert_parity_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> ($countones(frame_q) % 2) == 0);
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(FRAME_W));
endmodule

// File: rtl/mxs_serial_slave.sv
module mxs_serial_slave
  import mxs_pkg::*;
#(
  parameter int CONV_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic [RES_W:0]    conv_data_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [ADDR_W-1:0] mux_sel_o
);
  // ---- pin synchronisation (cs idles high) ----
  logic [2:0] pin_lvl;
  mxs_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_i   ({cs_n, sck, sdi}),
    .level_o (pin_lvl)
  );
  logic cs_hi, sck_lvl, sdi_lvl, sck_prev_q;
  assign cs_hi   = pin_lvl[2];
  assign sck_lvl = pin_lvl[1];
  assign sdi_lvl = pin_lvl[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev_q <= 1'b0;
    else        sck_prev_q <= sck_lvl;
  end

  // Named internal events
  logic sck_rise, sck_fall, selected;
  assign sck_rise = sck_lvl & ~sck_prev_q;
  assign sck_fall = ~sck_lvl & sck_prev_q;
  assign selected = ~cs_hi;

  logic conv_busy, conv_done, conv_start;
  logic bit_sample, bit_shift, last_bit, cmd_done, frame_msb;
  logic [CMD_W-1:0] cmd_word;
  mxs_state_e state_q, state_d;
  logic [ADDR_W-1:0] sel_next_q, sel_conv_q;

  // ---- conversion timing ----
  mxs_conv_timer #(.CYCLES(CONV_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (conv_start),
    .busy_o  (conv_busy),
    .done_o  (conv_done)
  );

  // ---- readout word and command shifting ----
  mxs_frame_shifter u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (conv_done),
    .frame_i    (build_frame(conv_data_i[RES_W], conv_data_i[RES_W-1:0], sel_conv_q)),
    .shift_i    (bit_shift),
    .sample_i   (bit_sample),
    .sdi_i      (sdi_lvl),
    .msb_o      (frame_msb),
    .last_o     (last_bit),
    .cmd_done_o (cmd_done),
    .cmd_word_o (cmd_word)
  );

  // ---- phase sequencing ----
  always_comb begin
    state_d    = state_q;
    conv_start = 1'b0;
    bit_sample = 1'b0;
    bit_shift  = 1'b0;
    unique case (state_q)
      ST_CONVERT: if (conv_done) state_d = ST_SLEEP;
      ST_SLEEP: begin
        if (selected && sck_rise) begin
          state_d    = ST_XFER;
          bit_sample = 1'b1;
        end
      end
      ST_XFER: begin
        if (!selected) begin
          conv_start = 1'b1;
          state_d    = ST_CONVERT;
        end else begin
          if (sck_rise) begin
            bit_sample = 1'b1;
            if (last_bit) begin
              conv_start = 1'b1;
              state_d    = ST_CONVERT;
            end
          end
          if (sck_fall) bit_shift = 1'b1;
        end
      end
      default: state_d = ST_CONVERT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_CONVERT;
    else        state_q <= state_d;
  end

  // ---- channel selection pipeline ----
  mxs_cmd_t cmd_dec;
  assign cmd_dec = decode_cmd(cmd_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_next_q <= '0;
      sel_conv_q <= '0;
    end else begin
      if (cmd_done && cmd_dec.load) sel_next_q <= cmd_dec.sel;
      if (conv_start)               sel_conv_q <= sel_next_q;
    end
  end

  // ---- outputs ----
  assign sdo_oe_o  = selected;
  assign sdo_o     = selected & ((state_q == ST_CONVERT) ? 1'b1 : frame_msb);
  assign mux_sel_o = sel_conv_q;

  // ---- assertions ----
  assert_done_to_sleep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> state_q == ST_SLEEP);
  assert_sleep_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && cs_hi) |=> (state_q == ST_SLEEP && !conv_busy));
  assert_abort_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_XFER && cs_hi) |=> (state_q == ST_CONVERT && conv_busy));
  assert_last_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_XFER && selected && sck_rise && last_bit) |=> conv_busy);
  assert_sel_applied_R10: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> mux_sel_o == $past(sel_next_q));
  assert_busy_matches_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_CONVERT) |-> !conv_busy);
endmodule

// File: tb/tb_mxs_serial_slave.sv
module tb_mxs_serial_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int CONV       = 40;
  localparam int NV         = 6;
  // {command byte, 24-bit conversion data}
  localparam logic [31:0] VEC [0:NV-1] = '{
    {8'hA3, 24'h800000},   // load 00011
    {8'h9F, 24'h7FFFFF},   // code 100: keep
    {8'h00, 24'h000000},   // code 000: keep
    {8'hBA, 24'h5A5A5A},   // load 11010
    {8'hD5, 24'hC3C3C3},   // code 110: keep
    {8'hA0, 24'h012345}    // load 00000
  };
  localparam logic [23:0] D_HOLD = 24'hABCDEF;
  localparam logic [23:0] D_A    = 24'h3C0F96;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic [23:0] conv_data = 24'h0;
  logic sdo, sdo_oe;
  logic [4:0] mux_sel;

  int errors = 0, checks = 0;
  bit finished = 1'b0;
  logic [4:0] m_next = 5'd0, m_conv = 5'd0;
  logic [31:0] got;

  always #(CLK_PERIOD/2) clk = ~clk;

  mxs_serial_slave #(.CONV_CYCLES(CONV), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .conv_data_i(conv_data), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .mux_sel_o(mux_sel)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_frame(input logic [23:0] d, input logic [4:0] sel);
    logic [31:0] f;
    int ones;
    f = 32'h0;
    f[29] = d[23];
    for (int k = 0; k < 23; k++) f[6+k] = d[k];
    f[5:1] = sel;
    ones = 0;
    for (int k = 1; k < 32; k++) ones += f[k];
    f[0] = ones[0];
    return f;
  endfunction

  task automatic wait_ready();
    bit ok;
    ok = 1'b0;
    cs_n = 1'b0;
    tick(HALF);
    for (int k = 0; k < 500; k++) begin
      if (sdo_oe === 1'b1 && sdo === 1'b0) begin ok = 1'b1; break; end
      tick(1);
    end
    chk("R4 conversion completes", {31'd0, ok}, 32'd1);
  endtask

  task automatic xfer(input logic [7:0] cmd, input int nbits, output logic [31:0] word);
    word = 32'h0;
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 8) ? cmd[7-i] : 1'b0;
      tick(HALF);
      word[31-i] = sdo;
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    conv_data = VEC[0][23:0];
    tick(5);
    rst_n = 1'b1;
    tick(2);
    // reset state
    chk("R2 oe low while deselected", {31'd0, sdo_oe}, 32'd0);
    chk("R1 reset selection", {27'd0, mux_sel}, 32'd0);
    cs_n = 1'b0;
    tick(4);
    chk("R2 oe high while selected", {31'd0, sdo_oe}, 32'd1);
    chk("R3 busy status during conversion", {31'd0, sdo}, 32'd1);
    cs_n = 1'b1;
    tick(HALF);

    // table-driven readouts
    for (int i = 0; i < NV; i++) begin
      wait_ready();
      xfer(VEC[i][31:24], 32, got);
      chk("R6 R10 readout word", got, exp_frame(VEC[i][23:0], m_conv));
      if (VEC[i][31:29] == 3'b101) m_next = VEC[i][28:24];   // R9 load code
      m_conv = m_next;
      conv_data = (i < NV-1) ? VEC[i+1][23:0] : D_HOLD;
      chk("R7 conversion restarts after 32 bits", {31'd0, sdo}, 32'd1);
      cs_n = 1'b1;
      tick(HALF);
      chk("R10 R9 selection in use", {27'd0, mux_sel}, {27'd0, m_conv});
    end

    // R5 / R11: select without clock, data changes while holding
    wait_ready();
    cs_n = 1'b1;
    tick(2);
    conv_data = ~D_HOLD;
    tick(60);
    cs_n = 1'b0;
    tick(HALF);
    chk("R5 still holding after select pulse", {31'd0, sdo}, 32'd0);
    xfer(8'h00, 32, got);
    chk("R11 R5 held result unchanged", got, exp_frame(D_HOLD, m_conv));
    m_conv = m_next;
    conv_data = D_A;
    cs_n = 1'b1;
    tick(HALF);

    // R8 abort after 4 bits: conversion restarts, no command applied
    wait_ready();
    xfer(8'hBF, 4, got);
    cs_n = 1'b1;
    tick(HALF);
    cs_n = 1'b0;
    tick(HALF);
    chk("R8 abort starts conversion", {31'd0, sdo}, 32'd1);
    m_conv = m_next;
    cs_n = 1'b1;
    tick(HALF);
    wait_ready();
    xfer(8'h00, 32, got);
    chk("R9 short command ignored", got, exp_frame(D_A, m_conv));
    cs_n = 1'b1;
    tick(HALF);

    // R8 abort right after 8 bits: load takes effect for the restarted conversion
    wait_ready();
    xfer(8'hAE, 8, got);
    cs_n = 1'b1;
    tick(HALF);
    m_next = 5'h0E;
    m_conv = m_next;
    chk("R8 R9 selection after 8-bit abort", {27'd0, mux_sel}, 32'h0E);
    wait_ready();
    xfer(8'h00, 32, got);
    chk("R10 address field after abort", got, exp_frame(D_A, 5'h0E));
    cs_n = 1'b1;
    tick(HALF);
    chk("R2 oe low after readout", {31'd0, sdo_oe}, 32'd0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule